// File: doc/BRIEF.md
# Guarded Multiplexed-Bus Register Slave

This block lets a small microcontroller reach a handful of on-chip registers over its multiplexed external bus. The host first puts an address on the bus and marks it with an address strobe. It then reads or writes one byte using active-low read and write strobes. The low address byte and the data byte share one 8-bit port. The block runs entirely from a fast local clock. Every strobe passes through a two-flop synchronizer, and all edges are found from those synchronized copies. The host bus cycle must therefore last several local clocks.

A sequencer with four states gives the block its robustness:

- **IDLE**: no address is held.
- **ADDR**: an address is latched and the block waits for a strobe.
- **READ**: a read is in progress.
- **WRITE**: a write is in progress.

The transitions are:

- **latch**: from any state to ADDR, on a synchronized address-strobe fall.
- **start-read**: from ADDR to READ.
- **start-write**: from ADDR to WRITE.
- **read-done**: from READ to IDLE.
- **commit**: from WRITE to IDLE, storing the byte.
- **collide**: from ADDR, READ or WRITE to IDLE, when both strobes are low together.

Any strobe seen in IDLE is dropped. A host that resets or powers up on its own therefore cannot corrupt registers or fight over the bus. The interface comes back by itself on the next address phase.

The map has two regions. Read-only input ports sit at 0x8000 upward. Writable output registers sit at 0x8080 upward and can also be read back. The tri-state port is split into `ad_in`, `ad_out` and an enable `ad_oe`.

Top module: `mbus_reg_slave`

## Requirements
- R1: On a synchronized falling edge of `ale`, the 16-bit address is captured as follows. Bit 15 is `hi_addr[5]`, bits 14..13 are zero, bits 12..8 are `hi_addr[4:0]`, and bits 7..0 are `ad_in`. So address 0x0080, or a value on `hi_addr[0]`, does not reach 0x8080.
- R2: A synchronized `ale` fall moves the sequencer to ADDR from any state, which marks the latched address as valid.
- R3: A read or write strobe that arrives while no valid address is held is ignored. `ad_oe` stays 0 and no output register changes, including right after a block reset.
- R4: `ad_oe` is 1 only in READ and only when the latched address is mapped. `ad_out` then carries the selected byte: input port i is `in_ports[8i+7:8i]` at 0x8000+i, and output register j is read back at 0x8080+j. `ad_out` is 0 whenever `ad_oe` is 0.
- R5: In WRITE, the return of `wr_n` to high stores the `ad_in` byte into output register j (`out_regs[8j+7:8j]`) when the latched address is 0x8080+j.
- R6: A completed read or write returns to IDLE, so a second strobe without a new address phase has no effect.
- R7: Addresses outside both regions, and writes aimed at input-port addresses, neither drive the port nor change any output register.
- R8: If the synchronized `rd_n` and `wr_n` are low together, the sequencer goes to IDLE with no access; a later strobe needs a new address.
- R9: A synchronous active-high `rst` puts the sequencer in IDLE, clears all output registers and leaves `ad_oe` at 0.
- R10: Strobes are sampled through two flops. A raw `rd_n` fall that is stable before rising edge k gives `ad_oe` high just after edge k+2. A raw `wr_n` rise before edge k stores the data at edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous active-high reset |
| ale | input | 1 | Address strobe from the host, address latched on its fall |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| ad_in | input | 8 | Multiplexed address/data port, input side |
| hi_addr | input | 6 | Upper address lines |
| ad_out | output | 8 | Multiplexed port, output side |
| ad_oe | output | 1 | Output enable for the multiplexed port |
| in_ports | input | NUM_IN*8 | Read-only input bytes |
| out_regs | output | NUM_OUT*8 | Output register contents |

## Verification
A behavioural model tracks the synchronizer delay and the address-valid flag, and is compared with the ports on every clock. Proper address-then-access cycles to both regions check decode and data paths. Address patterns that differ only in the upper-line placement show whether the high byte is composed correctly. Strobes with no preceding address phase, strobes after a completed access and strobes right after a reset separate a working guard from a plain latch-and-decode slave. Cycles with both strobes low show that an illegal cycle discards the address instead of performing a read or write.

// File: rtl/mbus_pkg.sv
`timescale 1ns/1ps
package mbus_pkg;
    localparam int AW  = 16;
    localparam int DW  = 8;
    localparam int HIW = 6;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ADDR  = 2'd1,
        S_READ  = 2'd2,
        S_WRITE = 2'd3
    } seq_state_e;

    // Upper line 5 goes to bit 15, lines 4..0 to bits 12..8, bits 14..13 zero.
    function automatic logic [AW-1:0] compose_addr(input logic [HIW-1:0] hi,
                                                   input logic [DW-1:0] lo);
        return {hi[5], 2'b00, hi[4:0], lo};
    endfunction
endpackage

// File: rtl/mbus_sync.sv
`timescale 1ns/1ps
module mbus_sync #(
    parameter int           W       = 3,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                meta[i] <= RST_VAL[i];
                q[i]    <= RST_VAL[i];
            end else begin
                meta[i] <= d[i];
                q[i]    <= meta[i];
            end
        end
    end
endmodule

// File: rtl/mbus_seq.sv
`timescale 1ns/1ps
module mbus_seq
    import mbus_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ale_s,
    input  logic       rd_n_s,
    input  logic       wr_n_s,
    output seq_state_e st,
    output logic       addr_load,
    output logic       wr_commit
);
    logic       ale_prev;
    logic       ale_fall;
    seq_state_e st_nx;

    always_ff @(posedge clk) begin
        if (rst) ale_prev <= 1'b0;
        else     ale_prev <= ale_s;
    end

    assign ale_fall = ale_prev & ~ale_s;

    // State register
    always_ff @(posedge clk) begin
        if (rst) st <= S_IDLE;
        else     st <= st_nx;
    end

    // Next state
    always_comb begin
        st_nx = st;
        if (ale_fall) begin
            st_nx = S_ADDR;                                    // latch
        end else begin
            unique case (st)
                S_IDLE:  st_nx = S_IDLE;                       // strobes dropped
                S_ADDR: begin
                    if (!rd_n_s && !wr_n_s) st_nx = S_IDLE;    // collide
                    else if (!rd_n_s)       st_nx = S_READ;    // start-read
                    else if (!wr_n_s)       st_nx = S_WRITE;   // start-write
                end
                S_READ:  if (rd_n_s || !wr_n_s) st_nx = S_IDLE;  // read-done / collide
                S_WRITE: if (wr_n_s || !rd_n_s) st_nx = S_IDLE;  // commit / collide
                default: st_nx = S_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        addr_load = ale_fall;
        wr_commit = (st == S_WRITE) && !ale_fall && wr_n_s && rd_n_s;
    end
endmodule

// File: rtl/mbus_regfile.sv
`timescale 1ns/1ps
module mbus_regfile
    import mbus_pkg::*;
#(
    parameter int          NUM_IN   = 4,
    parameter int          NUM_OUT  = 4,
    parameter logic [15:0] IN_BASE  = 16'h8000,
    parameter logic [15:0] OUT_BASE = 16'h8080
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [AW-1:0]          addr,
    input  logic                   wr_en,
    input  logic [DW-1:0]          wdata,
    input  logic [NUM_IN*DW-1:0]   in_ports,
    output logic [NUM_OUT*DW-1:0]  out_regs,
    output logic [DW-1:0]          rdata,
    output logic                   rd_hit
);
    logic [NUM_IN-1:0]  in_sel;
    logic [NUM_OUT-1:0] out_sel;

    for (genvar i = 0; i < NUM_IN; i++) begin : g_in
        localparam logic [AW-1:0] SLOT = IN_BASE + AW'(i);
        assign in_sel[i] = (addr == SLOT);
    end

    for (genvar j = 0; j < NUM_OUT; j++) begin : g_out
        localparam logic [AW-1:0] SLOT = OUT_BASE + AW'(j);
        assign out_sel[j] = (addr == SLOT);
        always_ff @(posedge clk) begin
            if (rst)                     out_regs[j*DW +: DW] <= '0;
            else if (wr_en && out_sel[j]) out_regs[j*DW +: DW] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_IN; i++)
            rdata = rdata | ({DW{in_sel[i]}} & in_ports[i*DW +: DW]);
        for (int j = 0; j < NUM_OUT; j++)
            rdata = rdata | ({DW{out_sel[j]}} & out_regs[j*DW +: DW]);
        rd_hit = (|in_sel) | (|out_sel);
    end
endmodule

// File: rtl/mbus_reg_slave.sv
`timescale 1ns/1ps
module mbus_reg_slave
    import mbus_pkg::*;
#(
    parameter int          NUM_IN   = 4,
    parameter int          NUM_OUT  = 4,
    parameter logic [15:0] IN_BASE  = 16'h8000,
    parameter logic [15:0] OUT_BASE = 16'h8080
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ale,
    input  logic                  rd_n,
    input  logic                  wr_n,
    input  logic [DW-1:0]         ad_in,
    input  logic [HIW-1:0]        hi_addr,
    output logic [DW-1:0]         ad_out,
    output logic                  ad_oe,
    input  logic [NUM_IN*DW-1:0]  in_ports,
    output logic [NUM_OUT*DW-1:0] out_regs
);
    localparam logic [2:0] STRB_IDLE = 3'b011;   // ale low, strobes high

    logic [2:0]    strb_raw;
    logic [2:0]    strb_s;
    logic          ale_s;
    logic          rd_n_s;
    logic          wr_n_s;
    seq_state_e    st;
    logic          addr_load;
    logic          wr_commit;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] rdata;
    logic          rd_hit;

    assign strb_raw = {ale, rd_n, wr_n};

    mbus_sync #(.W(3), .RST_VAL(STRB_IDLE)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (strb_raw),
        .q   (strb_s)
    );

    assign ale_s  = strb_s[2];
    assign rd_n_s = strb_s[1];
    assign wr_n_s = strb_s[0];

    mbus_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .ale_s     (ale_s),
        .rd_n_s    (rd_n_s),
        .wr_n_s    (wr_n_s),
        .st        (st),
        .addr_load (addr_load),
        .wr_commit (wr_commit)
    );

    always_ff @(posedge clk) begin
        if (rst)            addr_q <= '0;
        else if (addr_load) addr_q <= compose_addr(hi_addr, ad_in);
    end

    mbus_regfile #(
        .NUM_IN   (NUM_IN),
        .NUM_OUT  (NUM_OUT),
        .IN_BASE  (IN_BASE),
        .OUT_BASE (OUT_BASE)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .addr     (addr_q),
        .wr_en    (wr_commit),
        .wdata    (ad_in),
        .in_ports (in_ports),
        .out_regs (out_regs),
        .rdata    (rdata),
        .rd_hit   (rd_hit)
    );

    always_comb begin
        ad_oe  = (st == S_READ) && rd_hit;
        ad_out = ad_oe ? rdata : '0;
    end
endmodule

// File: rtl/mbus_reg_slave_chk.sv
`timescale 1ns/1ps
module mbus_reg_slave_chk
    import mbus_pkg::*;
#(
    parameter int OW = 32
) (
    input logic          clk,
    input logic          rst,
    input seq_state_e    st,
    input logic          rd_n_s,
    input logic          wr_n_s,
    input logic          addr_load,
    input logic [AW-1:0] addr_q,
    input logic          ad_oe,
    input logic [OW-1:0] out_regs
);
    AST_ADDR_ONLY_ON_ALE: assert property (@(posedge clk) disable iff (rst)
        !$stable(addr_q) |-> $past(addr_load)); // R1

    AST_ALE_SETS_VALID: assert property (@(posedge clk) disable iff (rst)
        addr_load |=> (st == S_ADDR)); // R2

    AST_REG_CHANGE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
        !$stable(out_regs) |-> ($past(st) == S_WRITE)); // R3

    AST_DRIVE_NEEDS_RD: assert property (@(posedge clk) disable iff (rst)
        ad_oe |-> !$past(rd_n_s)); // R4

    AST_READ_DONE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (st == S_READ && rd_n_s && wr_n_s && !addr_load) |=> (st == S_IDLE)); // R6

    AST_COLLIDE_DROPS: assert property (@(posedge clk) disable iff (rst)
        (!rd_n_s && !wr_n_s && !addr_load) |=> (st == S_IDLE)); // R8

    AST_RESET_CLEAN: assert property (@(posedge clk)
        rst |=> (out_regs == '0 && !ad_oe && st == S_IDLE)); // R9
endmodule

bind mbus_reg_slave mbus_reg_slave_chk #(.OW(NUM_OUT*DW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .st        (st),
    .rd_n_s    (rd_n_s),
    .wr_n_s    (wr_n_s),
    .addr_load (addr_load),
    .addr_q    (addr_q),
    .ad_oe     (ad_oe),
    .out_regs  (out_regs)
);

// File: tb/mbus_reg_slave_bench.sv
`timescale 1ns/1ps
module mbus_reg_slave_bench;
    localparam int NIN  = 4;
    localparam int NOUT = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ale = 1'b0;
    logic rd_n = 1'b1;
    logic wr_n = 1'b1;
    logic [7:0] ad_in = 8'h00;
    logic [5:0] hi_addr = 6'h00;
    logic [NIN*8-1:0] in_ports = 32'hD4C3B2A1;
    wire  [7:0] ad_out;
    wire        ad_oe;
    wire  [NOUT*8-1:0] out_regs;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mbus_reg_slave u_mbus_reg_slave (
        .clk(clk), .rst(rst), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
        .ad_in(ad_in), .hi_addr(hi_addr), .ad_out(ad_out), .ad_oe(ad_oe),
        .in_ports(in_ports), .out_regs(out_regs)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int         mst;            // 0 idle, 1 address held, 2 reading, 3 writing
    logic [15:0] maddr;
    logic [7:0]  mregs [NOUT];
    logic [2:0]  hist [$];      // raw {ale,rd_n,wr_n} at the last three edges

    function automatic bit m_in(input logic [15:0] a);
        return a >= 16'h8000 && a < 16'h8000 + NIN;
    endfunction
    function automatic bit m_out(input logic [15:0] a);
        return a >= 16'h8080 && a < 16'h8080 + NOUT;
    endfunction
    function automatic logic [7:0] m_val(input logic [15:0] a);
        if (m_in(a))  return in_ports[int'(a - 16'h8000)*8 +: 8];
        if (m_out(a)) return mregs[int'(a - 16'h8080)];
        return 8'h00;
    endfunction

    always @(posedge clk) begin
        logic [2:0] pv;
        logic [2:0] cur;
        if (rst) begin
            mst = 0;
            maddr = 16'h0;
            foreach (mregs[k]) mregs[k] = 8'h00;
            hist = '{3'b011, 3'b011, 3'b011};
        end else begin
            pv  = hist[0];
            cur = hist[1];
            if (pv[2] && !cur[2]) begin
                maddr = {hi_addr[5], 2'b00, hi_addr[4:0], ad_in};
                mst = 1;
            end else begin
                case (mst)
                    1: if (!cur[1] && !cur[0]) mst = 0;
                       else if (!cur[1]) mst = 2;
                       else if (!cur[0]) mst = 3;
                    2: if (cur[1] || !cur[0]) mst = 0;
                    3: if (cur[1] && cur[0]) begin
                           if (m_out(maddr)) mregs[int'(maddr - 16'h8080)] = ad_in;
                           mst = 0;
                       end else if (!cur[1]) mst = 0;
                    default: mst = 0;
                endcase
            end
            void'(hist.pop_front());
            hist.push_back({ale, rd_n, wr_n});
        end
    end

    always @(negedge clk) begin
        bit eo;
        if (!rst && !done) begin
            eo = (mst == 2) && (m_in(maddr) || m_out(maddr));
            chk(ad_oe === eo, "R10 ad_oe timing", {31'b0, ad_oe}, {31'b0, eo});
            chk(ad_out === (eo ? m_val(maddr) : 8'h00), "R4 ad_out value",
                {24'b0, ad_out}, {24'b0, eo ? m_val(maddr) : 8'h00});
            for (int k = 0; k < NOUT; k++)
                chk(out_regs[k*8 +: 8] === mregs[k], "R5 out_regs per cycle",
                    {24'b0, out_regs[k*8 +: 8]}, {24'b0, mregs[k]});
        end
    end

    // ---------------- host bus tasks ----------------
    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic addr_phase(input logic [15:0] a);
        @(negedge clk);
        hi_addr = {a[15], a[12:8]};
        ad_in = a[7:0];
        ale = 1'b1;
        idle(2);
        ale = 1'b0;
        idle(5);
        ad_in = 8'h5A;
        idle(1);
    endtask

    task automatic rd_cycle(output logic oe, output logic [7:0] d);
        rd_n = 1'b0;
        idle(6);
        oe = ad_oe;
        d = ad_out;
        rd_n = 1'b1;
        idle(4);
    endtask

    task automatic wr_cycle(input logic [7:0] d);
        ad_in = d;
        idle(1);
        wr_n = 1'b0;
        idle(5);
        wr_n = 1'b1;
        idle(5);
        ad_in = 8'h5A;
        idle(2);
    endtask

    task automatic both_low();
        rd_n = 1'b0;
        wr_n = 1'b0;
        idle(6);
        rd_n = 1'b1;
        wr_n = 1'b1;
        idle(4);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL R10 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic oe;
        logic [7:0] d;
        idle(5);
        rst = 1'b0;
        idle(2);
        chk(ad_oe === 1'b0, "R9 reset no drive", {31'b0, ad_oe}, 32'h0);
        chk(out_regs === '0, "R9 reset regs", out_regs, 32'h0);

        addr_phase(16'h8000); rd_cycle(oe, d);
        chk(oe === 1'b1, "R4 read port0 drive", {31'b0, oe}, 32'h1);
        chk(d === 8'hA1, "R1 read port0 data", {24'b0, d}, 32'hA1);
        addr_phase(16'h8003); rd_cycle(oe, d);
        chk(d === 8'hD4, "R4 read port3 data", {24'b0, d}, 32'hD4);

        addr_phase(16'h8080); wr_cycle(8'hA5);
        addr_phase(16'h8083); wr_cycle(8'h3C);
        chk(out_regs === 32'h3C0000A5, "R5 write regs", out_regs, 32'h3C0000A5);
        addr_phase(16'h8083); rd_cycle(oe, d);
        chk(oe === 1'b1 && d === 8'h3C, "R4 readback reg3", {24'b0, d}, 32'h3C);

        rd_cycle(oe, d);
        chk(oe === 1'b0, "R6 read without new address", {31'b0, oe}, 32'h0);
        wr_cycle(8'hFF);
        chk(out_regs === 32'h3C0000A5, "R6 write without new address", out_regs, 32'h3C0000A5);

        addr_phase(16'h8004); rd_cycle(oe, d);
        chk(oe === 1'b0, "R7 unmapped read", {31'b0, oe}, 32'h0);
        addr_phase(16'h8001); wr_cycle(8'h77);
        chk(out_regs === 32'h3C0000A5, "R7 write to input port", out_regs, 32'h3C0000A5);
        addr_phase(16'h0080); wr_cycle(8'h11);
        chk(out_regs === 32'h3C0000A5, "R1 bit15 clear unmapped", out_regs, 32'h3C0000A5);
        addr_phase(16'h8180); wr_cycle(8'h22);
        chk(out_regs === 32'h3C0000A5, "R1 upper line 0 placement", out_regs, 32'h3C0000A5);
        addr_phase(16'h8081); wr_cycle(8'h66);
        chk(out_regs === 32'h3C0066A5, "R5 write reg1", out_regs, 32'h3C0066A5);

        addr_phase(16'h8082);
        chk(ad_oe === 1'b0, "R2 address held no drive", {31'b0, ad_oe}, 32'h0);
        rst = 1'b1;
        idle(3);
        rst = 1'b0;
        idle(2);
        chk(out_regs === '0, "R9 mid-run reset clears", out_regs, 32'h0);
        wr_cycle(8'h44);
        chk(out_regs === '0, "R3 stale write after reset", out_regs, 32'h0);
        rd_cycle(oe, d);
        chk(oe === 1'b0, "R3 stale read after reset", {31'b0, oe}, 32'h0);

        addr_phase(16'h8082); both_low();
        chk(out_regs === '0, "R8 collision no write", out_regs, 32'h0);
        wr_cycle(8'h99);
        chk(out_regs === '0, "R8 collision clears address", out_regs, 32'h0);
        rd_cycle(oe, d);
        chk(oe === 1'b0, "R8 no drive after collision", {31'b0, oe}, 32'h0);

        addr_phase(16'h8082); wr_cycle(8'h5E);
        chk(out_regs === 32'h005E0000, "R2 fresh address recovers", out_regs, 32'h005E0000);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule